// File: doc/BRIEF.md
# Saturating Accumulator Shifter

This block sits after the accumulator of a multiply-accumulate datapath. It takes a 40-bit signed value, a 32-bit word with 8 guard bits above it, and either passes it through, shifts it arithmetically left by 1 to 8 places, or shifts it arithmetically right by 1 to 8 places. The result is registered on the clock edge that follows a valid strobe.

A left shift can push significant bits off the top of the 40-bit field. The block detects that loss and reports it as an overflow. When saturation is enabled, it then clamps the result to the 32-bit signed limit that matches the sign the value had before the shift, so a positive value can never become the most negative value, and the reverse. A left shift also clamps when the result fits in 40 bits but not in 32 bits. Only left shifts update the extension-in-use flag and the overflow flag. A sticky limit flag records every clamp until it is cleared on purpose.

Top module: `acc_shift_sat`

## Requirements
- R1: After reset, `out_value` is zero and `out_ext`, `out_ovf` and `out_lim` are all 0.
- R2: The op field is encoded as 0 = pass, 1 = left, 2 = right and 3 = pass. A pass, or any op with a shift amount of 0, stores `in_value` unchanged and leaves `out_ext` and `out_ovf` unchanged.
- R3: With `sat_en` low, a left shift by k stores the low 40 bits of `in_value` × 2^k. An amount above 8 is treated as 8.
- R4: A right shift by k stores `in_value` divided by 2^k, rounded toward minus infinity (the sign bit is copied into the vacated bits). It never clamps and leaves `out_ext` and `out_ovf` unchanged.
- R5: After a left shift, `out_ovf` is 1 exactly when the exact product `in_value` × 2^k lies outside the 40-bit signed range.
- R6: With `sat_en` high, a left shift that overflows stores 40'h00_7FFF_FFFF for a non-negative input and 40'hFF_8000_0000 for a negative input. The stored sign always equals the input sign.
- R7: With `sat_en` high, a left-shift result outside the range −2^31 to 2^31−1 is clamped to the limit of matching sign. After any left shift, `out_ext` is 1 exactly when bits 39 down to 31 of the stored value are not all equal.
- R8: `out_lim` becomes 1 on the edge after any clamp and stays 1 until `flag_clr` is sampled high. `flag_clr` acts whether or not `in_valid` is high. If a clamp and `flag_clr` fall in the same cycle, the flag ends up set.
- R9: `out_value` and the flags change only on the clock edge after a cycle with `in_valid` high. `out_lim` is the exception: it also responds to `flag_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| in_value | input | 40 | Signed accumulator value |
| op | input | 2 | Operation select (0 pass, 1 left, 2 right, 3 pass) |
| amount | input | 4 | Shift distance, values above 8 are treated as 8 |
| sat_en | input | 1 | Enables clamping to the 32-bit signed range |
| flag_clr | input | 1 | Clears the sticky limit flag |
| out_value | output | 40 | Registered result |
| out_ext | output | 1 | Guard bits of the result carry significance |
| out_ovf | output | 1 | Last left shift lost significant bits |
| out_lim | output | 1 | Sticky: a clamp has occurred |

## Verification
The case that needs care is a clamp and a clear of the sticky limit flag arriving in the same cycle. The bench provokes it by raising `flag_clr` at random during saturating left shifts, and also forces it directly with an overflowing shift. The expected flag is computed in the bench as the previous flag, cleared if `flag_clr` is high, then set again by any clamp. A second case covers positive inputs whose bit 38 moves into bit 39. For these the bench checks that the clamp takes the positive limit rather than the wrong-sign negative limit.

// File: rtl/acc_shift_pkg.sv
package acc_shift_pkg;
  typedef enum logic [1:0] {
    SH_PASS  = 2'd0,
    SH_LEFT  = 2'd1,
    SH_RIGHT = 2'd2,
    SH_RSV   = 2'd3
  } sh_op_e;

  typedef struct packed {
    logic ext;
    logic ovf;
    logic lim;
  } sh_flags_t;
endpackage

// File: rtl/asl_unit.sv
module asl_unit #(
  parameter int W     = 40,
  parameter int MAXSH = 8,
  parameter int AW    = 4
) (
  input  logic [W-1:0]  v,
  input  logic [AW-1:0] k,
  output logic [W-1:0]  res,
  output logic          lost
);
  localparam int XW = W + MAXSH;

  function automatic logic [XW-1:0] widen(input logic [W-1:0] x);
    return {{MAXSH{x[W-1]}}, x};
  endfunction

  logic [XW-1:0] wide;

  always_comb begin
    wide = widen(v) << k;
    res  = wide[W-1:0];
    lost = (wide[XW-1:W-1] != {(MAXSH+1){v[W-1]}});
  end
endmodule

// File: rtl/asr_unit.sv
module asr_unit #(
  parameter int W  = 40,
  parameter int AW = 4
) (
  input  logic [W-1:0]  v,
  input  logic [AW-1:0] k,
  output logic [W-1:0]  res
);
  always_comb res = W'($signed(v) >>> k);
endmodule

// File: rtl/clamp_unit.sv
module clamp_unit #(
  parameter int W    = 40,
  parameter int WORD = 32
) (
  input  logic [W-1:0] res,
  input  logic         lost,
  input  logic         src_neg,
  input  logic         en,
  output logic [W-1:0] out,
  output logic         clamped,
  output logic         ext
);
  localparam int HW = W - WORD + 1;
  localparam logic [W-1:0] MAX_POS = {{HW{1'b0}}, {(WORD-1){1'b1}}};
  localparam logic [W-1:0] MIN_NEG = {{HW{1'b1}}, {(WORD-1){1'b0}}};

  function automatic logic guard_busy(input logic [W-1:0] x);
    return x[W-1:WORD-1] != {HW{x[W-1]}};
  endfunction

  always_comb begin
    clamped = en && (lost || guard_busy(res));
    out     = clamped ? (src_neg ? MIN_NEG : MAX_POS) : res;
    ext     = guard_busy(out);
  end
endmodule

// File: rtl/acc_shift_sat.sv
module acc_shift_sat
  import acc_shift_pkg::*;
#(
  parameter int W     = 40,
  parameter int GUARD = 8,
  parameter int MAXSH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [39:0]  in_value,
  input  logic [1:0]   op,
  input  logic [3:0]   amount,
  input  logic         sat_en,
  input  logic         flag_clr,
  output logic [39:0]  out_value,
  output logic         out_ext,
  output logic         out_ovf,
  output logic         out_lim
);
  localparam int WORD = W - GUARD;
  localparam int AW   = $clog2(MAXSH + 1);

  logic [AW-1:0] k_eff;
  logic [W-1:0]  l_res, r_res, c_res, next_val;
  logic          ev_left, ev_right, ev_lost, ev_clamp, c_ext;
  sh_op_e        op_e;
  sh_flags_t     fl_q;

  always_comb begin
    op_e  = sh_op_e'(op);
    k_eff = (amount > AW'(MAXSH)) ? AW'(MAXSH) : amount;
    ev_left  = in_valid && (op_e == SH_LEFT)  && (k_eff != '0);
    ev_right = in_valid && (op_e == SH_RIGHT) && (k_eff != '0);
  end

  asl_unit #(.W(W), .MAXSH(MAXSH), .AW(AW)) u_asl (
    .v(in_value), .k(k_eff), .res(l_res), .lost(ev_lost)
  );

  asr_unit #(.W(W), .AW(AW)) u_asr (
    .v(in_value), .k(k_eff), .res(r_res)
  );

  logic c_hit;
  clamp_unit #(.W(W), .WORD(WORD)) u_clamp (
    .res(l_res), .lost(ev_lost), .src_neg(in_value[W-1]), .en(sat_en),
    .out(c_res), .clamped(c_hit), .ext(c_ext)
  );

  always_comb begin
    ev_clamp = ev_left && c_hit;
    if (ev_left)       next_val = c_res;
    else if (ev_right) next_val = r_res;
    else               next_val = in_value;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_value <= '0;
      fl_q      <= '0;
    end else begin
      if (in_valid) out_value <= next_val;
      if (ev_left) begin
        fl_q.ext <= c_ext;
        fl_q.ovf <= ev_lost;
      end
      fl_q.lim <= (fl_q.lim && !flag_clr) || ev_clamp;
    end
  end

  assign out_ext = fl_q.ext;
  assign out_ovf = fl_q.ovf;
  assign out_lim = fl_q.lim;
endmodule

// File: rtl/acc_shift_sat_chk.sv
module acc_shift_sat_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [39:0] in_value,
  input logic        sat_en,
  input logic        flag_clr,
  input logic        ev_left,
  input logic        ev_lost,
  input logic        ev_clamp,
  input logic [39:0] out_value,
  input logic        out_ext,
  input logic        out_ovf,
  input logic        out_lim
);
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_value)); // R9
  AST_FLAGS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_left |=> $stable({out_ext, out_ovf})); // R4
  AST_NO_WRONG_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_left && sat_en && ev_lost) |=> (out_value[39] == $past(in_value[39]))); // R6
  AST_SAT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_left && sat_en) |=> !out_ext); // R7
  AST_LIM_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_clamp |=> out_lim); // R8
  AST_LIM_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_lim && !flag_clr) |=> out_lim); // R8
  AST_LIM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !ev_clamp) |=> !out_lim); // R8
endmodule

bind acc_shift_sat acc_shift_sat_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_value(in_value),
  .sat_en(sat_en), .flag_clr(flag_clr), .ev_left(ev_left), .ev_lost(ev_lost),
  .ev_clamp(ev_clamp), .out_value(out_value), .out_ext(out_ext),
  .out_ovf(out_ovf), .out_lim(out_lim)
);

// File: tb/tb_acc_shift_sat.sv
module tb_acc_shift_sat;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic [39:0] in_value = '0;
  logic [1:0]  op = '0;
  logic [3:0]  amount = '0;
  logic        sat_en = 0;
  logic        flag_clr = 0;
  logic [39:0] out_value;
  logic        out_ext, out_ovf, out_lim;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [39:0] m_val = '0;
  logic        m_ext = 0, m_ovf = 0, m_lim = 0;

  always #2 clk = ~clk;

  acc_shift_sat dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_value(in_value),
    .op(op), .amount(amount), .sat_en(sat_en), .flag_clr(flag_clr),
    .out_value(out_value), .out_ext(out_ext), .out_ovf(out_ovf), .out_lim(out_lim)
  );

  function automatic longint sx40(input logic [39:0] x);
    return longint'($signed(x));
  endfunction

  function automatic bit outside32(input logic [39:0] x);
    longint s = sx40(x);
    return (s > 64'sd2147483647) || (s < -64'sd2147483648);
  endfunction

  task automatic model(input bit v, input logic [1:0] o, input logic [3:0] a,
                       input logic [39:0] x, input bit s, input bit c);
    int k = (a > 8) ? 8 : int'(a);
    bit clamp = 0;
    if (v && o == 2'd1 && k != 0) begin
      longint p = sx40(x) * (64'sd1 << k);
      bit ov = (p > 64'sd549755813887) || (p < -64'sd549755813888);
      logic [39:0] r = p[39:0];
      if (s && (ov || outside32(r))) begin
        r = x[39] ? 40'hFF_8000_0000 : 40'h00_7FFF_FFFF;
        clamp = 1;
      end
      m_val = r; m_ovf = ov; m_ext = outside32(r);
    end else if (v && o == 2'd2 && k != 0) begin
      m_val = 40'(sx40(x) >>> k);
    end else if (v) begin
      m_val = x;
    end
    m_lim = (m_lim && !c) || clamp;
  endtask

  task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    check({tag, " value"}, out_value, m_val);
    check({tag, " ext"}, {39'd0, out_ext}, {39'd0, m_ext});
    check({tag, " ovf"}, {39'd0, out_ovf}, {39'd0, m_ovf});
    check({tag, " lim"}, {39'd0, out_lim}, {39'd0, m_lim});
  endtask

  task automatic step(input string tag, input bit v, input logic [1:0] o,
                      input logic [3:0] a, input logic [39:0] x, input bit s, input bit c);
    in_valid = v; op = o; amount = a; in_value = x; sat_en = s; flag_clr = c;
    model(v, o, a, x, s, c);
    @(negedge clk);
    compare_all(tag);
  endtask

  function automatic logic [39:0] rnd_val(input int cls);
    logic [39:0] r = {$urandom, $urandom};
    case (cls)
      0: return r;
      1: return {{8{r[31]}}, r[31:0]};
      2: return {{16{r[23]}}, r[23:0]};
      default: return {r[39], {3{~r[39]}}, r[35:0]};
    endcase
  endfunction

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    compare_all("R1 reset");
    rst_n = 1;

    step("R3 left no sat", 1, 2'd1, 4'd2, 40'h00_4000_0000, 0, 0);
    check("R7 ext set", {39'd0, out_ext}, 40'd1);
    step("R2 amount zero", 1, 2'd1, 4'd0, 40'h12_3456_789A, 1, 0);
    step("R2 op3 pass", 1, 2'd3, 4'd5, 40'h00_0000_0042, 1, 0);
    step("R6 pos loses top", 1, 2'd1, 4'd1, 40'h40_0000_0001, 1, 0);
    check("R6 pos limit", out_value, 40'h00_7FFF_FFFF);
    step("R8 hold", 0, 2'd0, 4'd0, 40'h0, 0, 0);
    step("R8 clear", 0, 2'd0, 4'd0, 40'h0, 0, 1);
    step("R6 neg loses top", 1, 2'd1, 4'd1, 40'h80_0000_0000, 1, 1);
    check("R8 clamp beats clear", {39'd0, out_lim}, 40'd1);
    check("R6 neg limit", out_value, 40'hFF_8000_0000);
    step("R4 right sign fill", 1, 2'd2, 4'd8, 40'h80_0000_0000, 0, 1);
    check("R4 right value", out_value, 40'hFF_8000_0000);
    step("R3 amount over 8", 1, 2'd1, 4'd15, 40'h00_0000_0003, 0, 0);
    step("R5 ovf no sat", 1, 2'd1, 4'd8, 40'h01_0000_0000, 0, 0);
    step("R7 32-bit clamp", 1, 2'd1, 4'd1, 40'h00_4000_0000, 1, 0);
    step("R9 idle hold", 0, 2'd1, 4'd3, 40'h55_5555_5555, 1, 0);

    for (int i = 0; i < 4000; i++) begin
      bit v = ($urandom % 8) != 0;
      logic [1:0] o = 2'($urandom);
      logic [3:0] a = 4'($urandom);
      bit s = $urandom % 2;
      bit c = ($urandom % 6) == 0;
      step("R5/R7/R8/R9 random", v, o, a, rnd_val($urandom % 4), s, c);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule